// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Multicycle Execute

This block is a small in-order, single-issue integer pipeline with four stages: fetch, decode, execute and writeback. No separate memory stage exists. Arithmetic and the store to data memory both complete inside execute. A built-in five-word program evaluates `(S - R*(P+Q)) / T` on 16-bit unsigned values and stores the quotient at data address 42. P, Q, R, S and T are loaded into registers 0 to 4 from the `arg_vals` input while reset is held. Registers 5 and 6 hold the temporaries.

Execute latency depends on the operation. ADD, SUB and STORE take one cycle, and MUL and DIV take three. While a long operation is in execute, fetch and decode keep their contents and writeback receives a bubble. Decode takes a dependent operand directly from the execute result during that result's final execute cycle, so it never waits for writeback.

A sequencer state machine has three states. SEQ_RUN moves to SEQ_DRAIN once the last program word has been fetched. SEQ_DRAIN moves to SEQ_HALT when the final instruction retires. SEQ_HALT is terminal, raises `done` and freezes the counters. The execute unit has two states. It moves from EXS_IDLE to EXS_WORK on issue. From EXS_WORK it stays in EXS_WORK when its final cycle accepts a new issue, and it returns to EXS_IDLE when nothing is issued. Instruction words are 16 bits: opcode in [15:12] (ADD=1, SUB=2, MUL=3, DIV=4, STORE=5), destination in [11:9], first source in [8:6] and second source in [5:3]. A STORE takes its address from [5:0] and its data register from [11:9].

Top module: `tetra_pipe_core`

## Requirements
- R1: While `rst` is high, `done`, `cycle_cnt`, `retire_cnt` and `mem_we` are all zero.
- R2: The program stores `(S - R*(P+Q)) / T` at address 42, computed with 16-bit unsigned arithmetic where ADD and SUB wrap modulo 2^16. After `done`, `result_x` holds the same value.
- R3: MUL keeps only the low 16 bits of the product.
- R4: DIV by zero yields 16'hFFFF with no other effect. A nonzero divisor gives the unsigned truncated quotient.
- R5: ADD, SUB and STORE occupy execute for one cycle, and MUL and DIV occupy it for three. During a stall, fetch and decode hold their contents and writeback receives a bubble. Counting the first cycle after reset release as cycle 1, the STORE's memory write is visible in cycle 11.
- R6: A dependent instruction takes its operand from the producer's final execute cycle, so the whole program takes exactly 12 cycles (`cycle_cnt` = 12 at completion).
- R7: `retire_cnt` increments once per instruction leaving writeback and equals 5 when `done` rises.
- R8: `done` becomes visible in cycle 13, the cycle after the STORE leaves writeback. From then on `done` stays high and `cycle_cnt` and `retire_cnt` no longer change.
- R9: Each run performs exactly one data-memory write, and `mem_we` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads `arg_vals` into registers 0..4 |
| arg_vals | input | 80 | Five 16-bit operands; slice i (bits 16i+15:16i) goes to register i |
| done | output | 1 | High once the final instruction has retired |
| cycle_cnt | output | 16 | Cycles elapsed since reset release, frozen at completion |
| retire_cnt | output | 16 | Instructions that have left writeback |
| mem_we | output | 1 | Data-memory write strobe from execute |
| mem_addr | output | 6 | Data-memory write address |
| mem_wdata | output | 16 | Data-memory write data |
| result_x | output | 16 | Data-memory word at the result address 42 |

## Verification
The bench sweeps every combination of five operand values over all five registers: 3125 runs, including zero divisors and products that overflow 16 bits. For each run it checks the stored quotient, the exact cycle of the store, the total cycle count, the retire count and the cycle in which `done` rises.

- A divider that mishandles zero would store a quotient other than all ones.
- A multiplier that keeps the high product bits would give wrong results for the overflowing operands.
- Forwarding that waits for writeback, or a stall that releases decode one cycle early or late, would shift the store away from cycle 11 and the total away from 12 cycles.
- A stall that forwards a stale value would corrupt the quotient.

// File: rtl/tetra_pkg.sv
package tetra_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_MUL   = 4'd3,
        OP_DIV   = 4'd4,
        OP_STORE = 4'd5
    } op_e;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_DRAIN = 2'd1,
        SEQ_HALT  = 2'd2
    } seq_e;

    typedef enum logic {
        EXS_IDLE = 1'b0,
        EXS_WORK = 1'b1
    } exs_e;

    localparam int INSN_W      = 16;
    localparam int OPC_LSB     = 12;
    localparam int RD_LSB      = 9;
    localparam int RS1_LSB     = 6;
    localparam int RS2_LSB     = 3;
    localparam int REG_FW      = 3;
    localparam int ADDR_FW     = 6;
    localparam int PROG_LEN    = 5;
    localparam int NARG        = 5;
    localparam int RESULT_ADDR = 42;

    function automatic logic is_long(op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

    function automatic logic writes_reg(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

    function automatic logic [INSN_W-1:0] enc_alu(op_e op, logic [REG_FW-1:0] rd,
                                                  logic [REG_FW-1:0] rs1, logic [REG_FW-1:0] rs2);
        return {op, rd, rs1, rs2, 3'b000};
    endfunction

    function automatic logic [INSN_W-1:0] enc_store(logic [REG_FW-1:0] rd, logic [ADDR_FW-1:0] addr);
        return {OP_STORE, rd, 3'b000, addr};
    endfunction

endpackage

// File: rtl/tetra_fetch.sv
module tetra_fetch
    import tetra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic              hold,
    output logic              if_valid,
    output logic [INSN_W-1:0] if_word,
    output logic              if_last,
    output logic              prog_end
);
    localparam int PC_W = $clog2(PROG_LEN + 1);

    logic [PC_W-1:0] pc;

    function automatic logic [INSN_W-1:0] rom_word(logic [PC_W-1:0] idx);
        logic [INSN_W-1:0] w;
        case (int'(idx))
            0:       w = enc_alu(OP_ADD, 3'd5, 3'd0, 3'd1);
            1:       w = enc_alu(OP_MUL, 3'd6, 3'd2, 3'd5);
            2:       w = enc_alu(OP_SUB, 3'd5, 3'd3, 3'd6);
            3:       w = enc_alu(OP_DIV, 3'd6, 3'd5, 3'd4);
            4:       w = enc_store(3'd6, ADDR_FW'(RESULT_ADDR));
            default: w = '0;
        endcase
        return w;
    endfunction

    assign prog_end = (pc == PC_W'(PROG_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            if_valid <= 1'b0;
            if_word  <= '0;
            if_last  <= 1'b0;
        end else if (!hold) begin
            if (fetch_en && !prog_end) begin
                if_valid <= 1'b1;
                if_word  <= rom_word(pc);
                if_last  <= (pc == PC_W'(PROG_LEN - 1));
                pc       <= pc + 1'b1;
            end else begin
                if_valid <= 1'b0;
                if_word  <= '0;
                if_last  <= 1'b0;
            end
        end
    end

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(if_word) && $stable(if_valid) && $stable(pc))) else $error("fetch moved during stall"); // R5

endmodule

// File: rtl/tetra_regfile.sv
module tetra_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int NPRE   = 5,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPRE*DATA_W-1:0] preload,
    input  logic                   we,
    input  logic [RA_W-1:0]        waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [RA_W-1:0]        raddr_a,
    input  logic [RA_W-1:0]        raddr_b,
    output logic [DATA_W-1:0]      rdata_a,
    output logic [DATA_W-1:0]      rdata_b
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                if (gi < NPRE) regs[gi] <= preload[(gi % NPRE)*DATA_W +: DATA_W];
                else           regs[gi] <= '0;
            end else if (we && (waddr == RA_W'(gi))) begin
                regs[gi] <= wdata;
            end
        end
    end

    // write-first: a value being retired this cycle is visible to decode
    assign rdata_a = (we && waddr == raddr_a) ? wdata : regs[raddr_a];
    assign rdata_b = (we && waddr == raddr_b) ? wdata : regs[raddr_b];

endmodule

// File: rtl/tetra_exec.sv
module tetra_exec
    import tetra_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LONG_LAT  = 3,
    parameter int MEM_DEPTH = 64,
    localparam int MEM_AW   = $clog2(MEM_DEPTH),
    localparam int CNT_W    = $clog2(LONG_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  op_e               issue_op,
    input  logic [REG_FW-1:0] issue_rd,
    input  logic [DATA_W-1:0] issue_a,
    input  logic [DATA_W-1:0] issue_b,
    input  logic [MEM_AW-1:0] issue_addr,
    input  logic              issue_last,
    output logic              busy,
    output logic              res_valid,
    output logic              res_wr,
    output logic [REG_FW-1:0] res_rd,
    output logic [DATA_W-1:0] res_data,
    output logic              res_last,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] result_x
);
    exs_e              st, st_nx;
    logic [CNT_W-1:0]  cnt;
    op_e               op;
    logic [REG_FW-1:0] rd;
    logic [DATA_W-1:0] opa, opb;
    logic [MEM_AW-1:0] addr;
    logic              last;
    logic [CNT_W-1:0]  span_end;
    logic              final_cyc;
    logic [DATA_W-1:0] mem_q [MEM_DEPTH];

    assign span_end  = is_long(op) ? CNT_W'(LONG_LAT - 1) : '0;
    assign final_cyc = (st == EXS_WORK) && (cnt == span_end);
    assign busy      = (st == EXS_WORK) && !final_cyc;
    assign res_valid = final_cyc;

    always_comb begin
        st_nx = st;
        unique case (st)
            EXS_IDLE: if (issue_valid) st_nx = EXS_WORK;
            EXS_WORK: if (final_cyc && !issue_valid) st_nx = EXS_IDLE;
            default:  st_nx = EXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= EXS_IDLE;
            cnt  <= '0;
            op   <= OP_NOP;
            rd   <= '0;
            opa  <= '0;
            opb  <= '0;
            addr <= '0;
            last <= 1'b0;
        end else begin
            st <= st_nx;
            if (busy) begin
                cnt <= cnt + 1'b1;
            end else if (issue_valid) begin
                cnt  <= '0;
                op   <= issue_op;
                rd   <= issue_rd;
                opa  <= issue_a;
                opb  <= issue_b;
                addr <= issue_addr;
                last <= issue_last;
            end else begin
                op   <= OP_NOP;
                last <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:   res_data = opa + opb;
            OP_SUB:   res_data = opa - opb;
            OP_MUL:   res_data = opa * opb;
            OP_DIV:   res_data = (opb == '0) ? '1 : opa / opb;
            OP_STORE: res_data = opa;
            default:  res_data = '0;
        endcase
    end

    assign res_wr    = writes_reg(op);
    assign res_rd    = rd;
    assign res_last  = last;
    assign mem_we    = final_cyc && (op == OP_STORE);
    assign mem_addr  = addr;
    assign mem_wdata = opa;

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_addr] <= mem_wdata;
    end

    assign result_x = mem_q[MEM_AW'(RESULT_ADDR)];

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> (st == EXS_WORK && $stable(op) && $stable(opa) && $stable(opb))) else $error("operands moved mid-op"); // R5
    AST_SHORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && issue_valid && !is_long(issue_op)) |=> !busy) else $error("short op stalled"); // R5
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we) else $error("store strobe wider than one cycle"); // R9

endmodule

// File: rtl/tetra_pipe_core.sv
module tetra_pipe_core
    import tetra_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NREG      = 8,
    parameter int LONG_LAT  = 3,
    parameter int MEM_DEPTH = 64,
    parameter int CNT_W     = 16,
    localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NARG*DATA_W-1:0] arg_vals,
    output logic                   done,
    output logic [CNT_W-1:0]       cycle_cnt,
    output logic [CNT_W-1:0]       retire_cnt,
    output logic                   mem_we,
    output logic [MEM_AW-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic [DATA_W-1:0]      result_x
);
    seq_e              state, state_nx;
    logic              fetch_en, count_en;
    logic              if_valid, if_last, prog_end, busy;
    logic [INSN_W-1:0] if_word;

    op_e               dec_op;
    logic [REG_FW-1:0] dec_rd, dec_rs1, dec_rs2, raddr_a;
    logic [MEM_AW-1:0] dec_addr;
    logic [DATA_W-1:0] rf_a, rf_b, opnd_a, opnd_b;
    logic              issue_valid;

    logic              res_valid, res_wr, res_last;
    logic [REG_FW-1:0] res_rd;
    logic [DATA_W-1:0] res_data;

    logic              wb_valid, wb_wr, wb_last;
    logic [REG_FW-1:0] wb_rd;
    logic [DATA_W-1:0] wb_data;

    // ---------------- fetch ----------------
    tetra_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .fetch_en (fetch_en),
        .hold     (busy),
        .if_valid (if_valid),
        .if_word  (if_word),
        .if_last  (if_last),
        .prog_end (prog_end)
    );

    // ---------------- decode ----------------
    assign dec_op   = op_e'(if_word[OPC_LSB +: 4]);
    assign dec_rd   = if_word[RD_LSB  +: REG_FW];
    assign dec_rs1  = if_word[RS1_LSB +: REG_FW];
    assign dec_rs2  = if_word[RS2_LSB +: REG_FW];
    assign dec_addr = MEM_AW'(if_word[ADDR_FW-1:0]);
    assign raddr_a  = (dec_op == OP_STORE) ? dec_rd : dec_rs1;

    tetra_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .NPRE   (NARG)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .preload (arg_vals),
        .we      (wb_valid && wb_wr),
        .waddr   (wb_rd),
        .wdata   (wb_data),
        .raddr_a (raddr_a),
        .raddr_b (dec_rs2),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // forward from the final execute cycle ahead of the register file
    always_comb begin
        opnd_a = rf_a;
        opnd_b = rf_b;
        if (res_valid && res_wr && res_rd == raddr_a) opnd_a = res_data;
        if (res_valid && res_wr && res_rd == dec_rs2) opnd_b = res_data;
    end

    assign issue_valid = if_valid && !busy && (dec_op != OP_NOP);

    // ---------------- execute ----------------
    tetra_exec #(
        .DATA_W    (DATA_W),
        .LONG_LAT  (LONG_LAT),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_exec (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_op    (dec_op),
        .issue_rd    (dec_rd),
        .issue_a     (opnd_a),
        .issue_b     (opnd_b),
        .issue_addr  (dec_addr),
        .issue_last  (if_last),
        .busy        (busy),
        .res_valid   (res_valid),
        .res_wr      (res_wr),
        .res_rd      (res_rd),
        .res_data    (res_data),
        .res_last    (res_last),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .result_x    (result_x)
    );

    // ---------------- writeback ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_wr    <= 1'b0;
            wb_last  <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= res_valid;
            wb_wr    <= res_valid && res_wr;
            wb_last  <= res_valid && res_last;
            wb_rd    <= res_rd;
            wb_data  <= res_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           retire_cnt <= '0;
        else if (wb_valid) retire_cnt <= retire_cnt + 1'b1;
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_RUN:   if (prog_end) state_nx = SEQ_DRAIN;
            SEQ_DRAIN: if (wb_valid && wb_last) state_nx = SEQ_HALT;
            SEQ_HALT:  state_nx = SEQ_HALT;
            default:   state_nx = SEQ_HALT;
        endcase
    end

    always_comb begin
        fetch_en = (state == SEQ_RUN);
        count_en = (state != SEQ_HALT);
        done     = (state == SEQ_HALT);
    end

    always_ff @(posedge clk) begin
        if (rst)           cycle_cnt <= '0;
        else if (count_en) cycle_cnt <= cycle_cnt + 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (retire_cnt == '0 && cycle_cnt == '0 && !done)) else $error("reset state wrong"); // R1
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !wb_valid) else $error("writeback not bubbled on stall"); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(cycle_cnt) && $stable(retire_cnt))) else $error("counters moved after done"); // R8
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (retire_cnt == CNT_W'(PROG_LEN))) else $error("done with wrong retire count"); // R7

endmodule

// File: tb/tetra_pipe_core_tb.sv
module tetra_pipe_core_tb_top;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5*W-1:0] arg_vals = '0;
    logic          done, mem_we;
    logic [15:0]   cycle_cnt, retire_cnt;
    logic [5:0]    mem_addr;
    logic [W-1:0]  mem_wdata, result_x;

    int total = 0;
    int bad   = 0;
    int ticks = 0;

    always #5 clk = ~clk;

    tetra_pipe_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .arg_vals   (arg_vals),
        .done       (done),
        .cycle_cnt  (cycle_cnt),
        .retire_cnt (retire_cnt),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .result_x   (result_x)
    );

    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            bad++;
            total++;
            $display("FAIL R5 watchdog: actual=%0d expected below 150000 cycles", ticks);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [W-1:0] p, input logic [W-1:0] q, input logic [W-1:0] r,
                            input logic [W-1:0] s, input logic [W-1:0] t);
        logic [W-1:0] sum, prod, diff, quo;
        logic [31:0]  wide;
        string        tag;
        int stores, st_cyc, st_addr, st_data, done_cyc, cc, rc;
        sum  = p + q;
        prod = r * sum;
        diff = s - prod;
        quo  = (t == '0) ? 16'hFFFF : diff / t;
        wide = 32'(r) * 32'(sum);
        if (t == '0)              tag = "R4";
        else if (wide[31:16] != 0) tag = "R3";
        else                       tag = "R2";

        rst = 1'b1;
        arg_vals = {t, s, r, q, p};
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check(!done && cycle_cnt == 0 && retire_cnt == 0 && !mem_we, "R1", "reset state",
              int'({done, mem_we}) + int'(cycle_cnt) + int'(retire_cnt), 0);
        rst = 1'b0;

        stores = 0; st_cyc = 0; st_addr = 0; st_data = 0;
        done_cyc = 0; cc = 0; rc = 0;
        for (int c = 1; c <= 40; c++) begin
            if (mem_we) begin
                stores++;
                st_cyc  = c;
                st_addr = int'(mem_addr);
                st_data = int'(mem_wdata);
            end
            if (done && done_cyc == 0) begin
                done_cyc = c;
                cc = int'(cycle_cnt);
                rc = int'(retire_cnt);
            end
            if (done_cyc != 0 && c >= done_cyc + 3) break;
            @(negedge clk);
            #1;
        end

        check(stores == 1, "R9", "store count", stores, 1);
        check(st_cyc == 11, "R5", "store cycle", st_cyc, 11);
        check(st_addr == 42, "R2", "store address", st_addr, 42);
        check(st_data == int'(quo), tag, "stored value", st_data, int'(quo));
        check(result_x == quo, "R2", "result word", int'(result_x), int'(quo));
        check(done_cyc == 13, "R8", "done cycle", done_cyc, 13);
        check(cc == 12, "R6", "total cycles", cc, 12);
        check(rc == 5, "R7", "retire count", rc, 5);
        check(done && cycle_cnt == 16'd12 && retire_cnt == 16'd5, "R8", "frozen cycle count",
              int'(cycle_cnt), 12);
    endtask

    initial begin
        logic [W-1:0] vals [5];
        vals[0] = 16'd0;
        vals[1] = 16'd1;
        vals[2] = 16'd7;
        vals[3] = 16'd300;
        vals[4] = 16'hFFFF;
        for (int ip = 0; ip < 5; ip++)
            for (int iq = 0; iq < 5; iq++)
                for (int ir = 0; ir < 5; ir++)
                    for (int is = 0; is < 5; is++)
                        for (int it = 0; it < 5; it++)
                            run_case(vals[ip], vals[iq], vals[ir], vals[is], vals[it]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule